// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block holds the digital control of an 8-bit converter that is read over a three-wire serial link. A free-running internal clock runs all of its logic. The serial clock and the active-low chip select come from an external controller and have no timing relationship with that clock. Each frame shifts out the result of the previous conversion, most significant bit first, on a data line that has an enable. During the same frame the block starts tracking the input. On the last serial edge it freezes the input and runs a fixed hold-and-convert window.

An 8-bit parallel input takes the place of the analog input. The conversion is modelled as committing the frozen value to the result register at the end of the window, and a one-cycle done strobe marks that moment. A qualified chip-select assertion that arrives while the window is running cancels the conversion. The result register then keeps its earlier value. Chip select may stay low over several frames. In that case the next frame starts on the first serial edges after the window closes.

Top module: `adc_seq`

## Requirements
- R1: While `csN` is high, `dataOe` is 0 and serial clock edges change neither the result register nor the bit position of the next frame, and they start no conversion.
- R2: A low level on `csN` is accepted only after it has been seen on two rising edges of the internal clock, followed by a falling edge. Applied half a cycle after a rising edge, `dataOe` is still 0 after the third rising edge and is 1 after the fifth. A low pulse that spans only one rising edge is never accepted.
- R3: When `csN` rises, `dataOe` drops at once, with no clock edge.
- R4: As soon as chip select is accepted, `dataOut` carries bit 7 of the current result. After reset the result is 0x00.
- R5: Falling serial clock edges 1 through 7 of a frame place result bits 6 down to 0 on `dataOut`, one bit per edge, in that order.
- R6: The 8th falling serial edge starts a 36-cycle window (4 hold cycles plus 32 conversion cycles). `convDone` pulses for exactly one cycle 36 to 40 internal cycles after that edge.
- R7: The converted value is the `dIn` value tracked between the 4th and the 8th falling edge and frozen at the 8th. Values on `dIn` before the 5th edge, or after the 8th, do not affect it.
- R8: An accepted chip-select assertion during the window aborts the conversion. No `convDone` follows, and the next readout shows the earlier result.
- R9: Raising `csN` during the window neither stops nor delays the conversion.
- R10: If `csN` stays low across the end of the window, the new result's bit 7 appears on `dataOut` and the next 8 falling serial edges run a new frame without `csN` toggling.
- R11: While `rstN` is low, `dataOe` and `convDone` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous; bits advance on falling edges |
| dIn | input | 8 | Parallel stand-in for the analog input |
| dataOut | output | 1 | Serial data bit, valid while `dataOe` is 1 |
| dataOe | output | 1 | Drive enable of the serial data line (0 = high impedance) |
| convDone | output | 1 | One-cycle pulse when a conversion commits its result |

## Verification
Two events can claim the same cycle of the controller: the end-of-window commit and the acceptance of a new chip-select assertion. The controller gives the abort priority. The bench raises and lowers chip select partway through a window. It then reads the next frame and counts every done pulse, which shows that the commit was suppressed and the earlier result survived. The back-to-back case exercises the other side of that boundary, where a commit is followed directly by a new frame load with chip select held low.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WINDOW = 2'd2
  } seqState_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;    // copy result into the shift register
    logic shift;   // advance the serial shift register
    logic track;   // follow dIn (sampling phase)
    logic commit;  // conversion finished: result <= frozen sample
  } dpStrobe_t;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic [DATA_W-1:0] dIn,
  output logic              msbOut
);

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] trackReg;
  logic [DATA_W-1:0] resultReg;

  // Sample tracker: follows dIn while tracking, freezes otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         trackReg <= '0;
    else if (st.track) trackReg <= dIn;
  end

  // Result register and serial shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      shReg     <= '0;
    end else if (st.commit) begin
      resultReg <= trackReg;
      shReg     <= trackReg;
    end else if (st.load) begin
      shReg     <= resultReg;
    end else if (st.shift) begin
      shReg     <= {shReg[DATA_W-2:0], 1'b0};
    end
  end

  assign msbOut = shReg[DATA_W-1];

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(resultReg)); // R8

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SAMPLE_AFTER = 4,
  parameter int HOLD_CYC     = 4,
  parameter int CONV_CYC     = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int CS_QUAL      = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  output dpStrobe_t st,
  output logic      csAccepted,
  output logic      convDone
);

  localparam int WIN    = HOLD_CYC + CONV_CYC;
  localparam int WIN_W  = $clog2(WIN + 1);
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam int QUAL_W = $clog2(CS_QUAL + 1);

  logic csSync, sclkSync, sclkPrev;
  logic csAccQ, csFall, sclkFall;
  logic [QUAL_W-1:0] lowCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [WIN_W-1:0]  winCnt;
  seqState_e state, nxtState;

  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csSync (
    .clk(clk), .rstN(rstN), .din(csN), .q(csSync));

  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclkSync (
    .clk(clk), .rstN(rstN), .din(sclk), .q(sclkSync));

  // Chip-select qualifier: count rising edges with select low,
  // then accept on the next falling edge of the internal clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             lowCnt <= '0;
    else if (csSync)                       lowCnt <= '0;
    else if (lowCnt != QUAL_W'(CS_QUAL))   lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) csAccepted <= 1'b0;
    else       csAccepted <= !csSync && (lowCnt == QUAL_W'(CS_QUAL));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csAccQ   <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      csAccQ   <= csAccepted;
      sclkPrev <= sclkSync;
    end
  end

  assign csFall   = csAccepted & ~csAccQ;
  assign sclkFall = sclkPrev & ~sclkSync;

  // Sequencer
  always_comb begin
    nxtState  = state;
    st        = '0;
    st.track  = (state == ST_READ) && (bitCnt >= BIT_W'(SAMPLE_AFTER));
    case (state)
      ST_IDLE: begin
        st.load = 1'b1;
        if (csFall) nxtState = ST_READ;
      end
      ST_READ: begin
        if (!csAccepted) begin
          nxtState = ST_IDLE;
        end else if (sclkFall) begin
          st.shift = 1'b1;
          if (bitCnt == BIT_W'(DATA_W - 1)) nxtState = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (csFall) begin
          nxtState = ST_READ;              // abort, old result stays
        end else begin
          st.load = !csAccepted;
          if (winCnt == WIN_W'(WIN - 1)) begin
            st.commit = 1'b1;
            nxtState  = csAccepted ? ST_READ : ST_IDLE;
          end
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      winCnt   <= '0;
      convDone <= 1'b0;
    end else begin
      state    <= nxtState;
      convDone <= st.commit;
      if (nxtState != ST_READ) bitCnt <= '0;
      else if (st.shift)       bitCnt <= bitCnt + 1'b1;
      if (state == ST_WINDOW && nxtState == ST_WINDOW) winCnt <= winCnt + 1'b1;
      else                                             winCnt <= '0;
    end
  end

  AST_CS_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csAccQ) |-> ($past(!csSync) && $past(!csSync, 2))); // R2

  AST_DONE_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> ($past(state) == ST_WINDOW)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone); // R6

  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW && csFall) |=> !convDone); // R8

  AST_NO_SHIFT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW) |-> !st.track); // R7

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SAMPLE_AFTER = 4,
  parameter int HOLD_CYC     = 4,
  parameter int CONV_CYC     = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int CS_QUAL      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic [DATA_W-1:0] dIn,
  output logic              dataOut,
  output logic              dataOe,
  output logic              convDone
);

  dpStrobe_t st;
  logic      csAccepted;
  logic      msbOut;

  adc_seq_ctrl #(
    .DATA_W(DATA_W), .SAMPLE_AFTER(SAMPLE_AFTER), .HOLD_CYC(HOLD_CYC),
    .CONV_CYC(CONV_CYC), .SYNC_STAGES(SYNC_STAGES), .CS_QUAL(CS_QUAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .st(st), .csAccepted(csAccepted), .convDone(convDone));

  adc_seq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .dIn(dIn), .msbOut(msbOut));

  // Raw select gates the driver so deassertion is immediate
  assign dataOe  = ~csN & csAccepted;
  assign dataOut = msbOut;

  AST_OE_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !dataOe); // R1

endmodule

// File: tb/sim_adc_seq.sv
module sim_adc_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic [7:0] dIn = 8'h00;
  logic dataOut, dataOe, convDone;

  int nChecks = 0;
  int nFails  = 0;
  int doneCnt = 0;
  logic [7:0] expResult = 8'h00;
  bit finished = 1'b0;

  adc_seq u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .dIn(dIn),
    .dataOut(dataOut), .dataOe(dataOe), .convDone(convDone));

  always #10 clk = ~clk;

  always @(posedge clk) if (rstN && convDone) doneCnt++;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  // Read one frame; returns right at the 8th falling edge
  task automatic readFrame(input logic [7:0] early, input logic [7:0] late,
                           output logic [7:0] got);
    dIn = early;
    got[7] = dataOut;
    for (int i = 6; i >= 0; i--) begin
      sclk = 1'b1; cyc(6);
      sclk = 1'b0; cyc(6);
      got[i] = dataOut;
      if (i == 2) dIn = late;
    end
    sclk = 1'b1; cyc(6);
    sclk = 1'b0;
  endtask

  task automatic doneWindow(input string tag, input int offset);
    int n = offset;
    bit seen = 1'b0;
    while (!seen && n < 70) begin
      cyc(1); n++;
      seen = convDone;
    end
    check({tag, " R6 done seen"}, seen, 1);
    check({tag, " R6 window length"}, (n >= 36 && n <= 40), 1);
    cyc(1);
    check({tag, " R6 single pulse"}, convDone, 0);
  endtask

  task automatic tReset;
    cyc(3);
    check("R11 oe in reset", dataOe, 0);
    check("R11 done in reset", convDone, 0);
    rstN = 1'b1;
    cyc(2);
  endtask

  task automatic tBasic;
    logic [7:0] got;
    csN = 1'b0;
    cyc(3);
    check("R2 not yet accepted", dataOe, 0);
    cyc(2);
    check("R2 accepted", dataOe, 1);
    check("R4 reset result msb", dataOut, 0);
    readFrame(8'hA5, 8'hA5, got);
    check("R5 first readout", got, 8'h00);
    cyc(5);
    dIn = 8'hFF;                       // after hold: must be ignored (R7)
    doneWindow("basic", 5);
    expResult = 8'hA5;
    csN = 1'b1;
    #1;
    check("R3 oe drops without clock", dataOe, 0);
    cyc(4);
    csN = 1'b0;
    cyc(6);
    check("R4 msb on accept", dataOut, expResult[7]);
    readFrame(8'h3C, 8'h3C, got);
    check("R5 R7 readout of converted value", got, expResult);
    doneWindow("second", 0);
    expResult = 8'h3C;
    csN = 1'b1;
    cyc(4);
  endtask

  task automatic tCsHighSclk;
    logic [7:0] got;
    int d0 = doneCnt;
    int oeSeen = 0;
    for (int k = 0; k < 10; k++) begin
      sclk = 1'b1; cyc(5);
      if (dataOe) oeSeen++;
      sclk = 1'b0; cyc(5);
      if (dataOe) oeSeen++;
    end
    check("R1 oe off while deselected", oeSeen, 0);
    cyc(50);
    check("R1 no conversion from ignored sclk", doneCnt - d0, 0);
    csN = 1'b0;
    cyc(6);
    readFrame(8'h5A, 8'h5A, got);
    check("R1 frame unaffected by ignored sclk", got, expResult);
    doneWindow("cshigh-sclk", 0);
    expResult = 8'h5A;
    csN = 1'b1;
    cyc(4);
  endtask

  task automatic tGlitch;
    int oeSeen = 0;
    csN = 1'b0;
    cyc(1);
    csN = 1'b1;
    for (int k = 0; k < 10; k++) begin
      cyc(1);
      if (dataOe) oeSeen++;
    end
    check("R2 one-edge glitch rejected", oeSeen, 0);
  endtask

  task automatic tAbort;
    logic [7:0] got;
    int d0;
    csN = 1'b0;
    cyc(6);
    readFrame(8'hC3, 8'hC3, got);
    check("R5 pre-abort readout", got, expResult);
    d0 = doneCnt;
    cyc(8);
    csN = 1'b1;
    cyc(3);
    csN = 1'b0;
    cyc(6);
    check("R8 msb after abort", dataOut, expResult[7]);
    readFrame(8'h66, 8'h66, got);
    check("R8 readout keeps earlier result", got, expResult);
    check("R8 no done from aborted conversion", doneCnt - d0, 0);
    doneWindow("after-abort", 0);
    expResult = 8'h66;
    csN = 1'b1;
    cyc(4);
  endtask

  task automatic tCsHighInWindow;
    logic [7:0] got;
    csN = 1'b0;
    cyc(6);
    readFrame(8'h99, 8'h99, got);
    check("R5 readout", got, expResult);
    cyc(4);
    csN = 1'b1;
    doneWindow("R9 deselected window", 4);
    expResult = 8'h99;
    cyc(2);
    csN = 1'b0;
    cyc(6);
    readFrame(8'h12, 8'h12, got);
    check("R9 conversion completed while deselected", got, expResult);
    doneWindow("R9 follow-up", 0);
    expResult = 8'h12;
    csN = 1'b1;
    cyc(4);
  endtask

  task automatic tBackToBack;
    logic [7:0] got;
    csN = 1'b0;
    cyc(6);
    readFrame(8'hF0, 8'hE7, got);      // value before 5th edge is dropped (R7)
    check("R5 readout", got, expResult);
    doneWindow("b2b first", 0);
    expResult = 8'hE7;
    cyc(3);
    check("R10 new msb without cs toggle", dataOut, expResult[7]);
    readFrame(8'h00, 8'h00, got);
    check("R10 R7 back-to-back frame", got, expResult);
    doneWindow("b2b second", 0);
    csN = 1'b1;
    cyc(4);
  endtask

  initial begin
    tReset;
    tBasic;
    tCsHighSclk;
    tGlitch;
    tAbort;
    tCsHighInWindow;
    tBackToBack;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule